// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the bus-facing register layer of a simple serial port on a 32-bit memory-mapped bus. A bus access picks one of four word registers by its word index: receive data, transmit data, status and control. Every access completes in the cycle it is presented, with no wait states. Read data is combinational while `bus_sel` is high and `bus_we` is low, and write side effects take place at the next rising clock edge.

On the line side, received bytes enter through a valid/ready byte stream. Back-pressure is advisory only. `rx_ready` is high whenever the receive ring has a free slot. A byte offered while `rx_ready` is low is not held for a retry: it is dropped, and that cycle counts as an overrun. Transmit bytes leave through a one-cycle strobe in the same cycle as the bus write, with no flow control.

Received bytes are kept in an 8-entry circular ring made of a write pointer and an occupancy count. The read slot is the write pointer minus the count. A sticky pending flag, gated by an enable bit in the control register, drives one level interrupt.

Top module: `uart_regfront`

## Requirements
- R1: The word index is `bus_addr[7:2]`. Index 0 is RX data, 1 is TX data, 2 is STATUS and 3 is CTRL. Indices of 4 and above read as 0 and ignore writes. A write to index 0 has no effect.
- R2: A CTRL write stores all 32 bits, and the stored value reads back. CTRL bit 4 is the interrupt enable, and CTRL bit 0 has no effect other than being stored.
- R3: The STATUS read value has these bits:
  - bit 0: ring not empty
  - bit 1: ring holds 8 bytes
  - bit 2: always 1
  - bit 3: always 0
  - bit 4: pending flag
  - bit 5: overrun flag
  - bits 31:6: zero
- R4: A CTRL write with bit 1 set clears the write pointer, the count and the overrun flag. A byte offered in that same cycle is lost and does not set overrun.
- R5: The ring holds 8 bytes and returns them in arrival order. The write pointer wraps modulo 8, and the read slot is (write pointer minus count) modulo 8.
- R6: `rx_ready` is high exactly while the count is below 8. A byte offered while the count is 8 leaves the ring unchanged and sets the overrun flag.
- R7: An RX read returns the byte in the read slot and lowers the count by one if the count is nonzero. A read of an empty ring returns the stale byte in that slot and leaves the count at 0.
- R8: A TX write raises `tx_strobe` in the same cycle, with `tx_byte` equal to `bus_wdata[7:0]`. It also stores the 32-bit value, which reads back at index 1, and it sets the pending flag.
- R9: Accepting a byte sets the pending flag, so the flag is 1 whenever the count is nonzero. A STATUS read while the ring is empty, with no byte being accepted, clears it. `irq` equals the pending flag AND CTRL bit 4.
- R10: A STATUS write changes no state and raises `status_wr_err` for that cycle.
- R11: After reset, all registers, pointers and flags are 0. A STATUS read therefore returns 0x04, and `irq` is 0.
- R12: An RX read and an accepted byte in the same cycle return the old read-slot byte. The count then changes by +1 if the ring was empty, and otherwise stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Ring has room |
| rx_data | input | 8 | Received byte |
| tx_strobe | output | 1 | Transmit byte valid this cycle |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| status_wr_err | output | 1 | Illegal STATUS write this cycle |

## Verification
The bench fills the ring past capacity after the write pointer has moved off zero. A read slot computed without the modulo, or a count that saturates wrongly, would then return bytes out of order or accept a ninth byte. It reads an empty ring twice: a design that underflows the count would afterwards report data as available. It offers a byte in the same cycle as an RX read and in the same cycle as an RX reset, where a wrong priority leaves a count off by one or a stale overrun. It also checks that a STATUS read clears the pending flag only when the ring is empty, and that a STATUS write leaves every flag unchanged.

// File: rtl/uart_regfront_pkg.sv
`timescale 1ns/1ps
package uart_regfront_pkg;
  typedef enum logic [1:0] {
    IDX_RXD  = 2'd0,
    IDX_TXD  = 2'd1,
    IDX_STAT = 2'd2,
    IDX_CTRL = 2'd3
  } reg_idx_e;

  localparam int ST_RXAVAIL = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_PEND    = 4;
  localparam int ST_OVR     = 5;

  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;
endpackage

// File: rtl/uart_bus_decode.sv
`timescale 1ns/1ps
module uart_bus_decode
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_any,
  output logic              in_map,
  output reg_idx_e          idx,
  output logic              rd_rxd,
  output logic              rd_stat,
  output logic              wr_txd,
  output logic              wr_stat,
  output logic              wr_ctrl
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] widx;
  logic          unused_lsb;

  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];
  assign in_map     = (widx >> 2) == '0;
  assign idx        = reg_idx_e'(widx[1:0]);

  logic rd_hit, wr_hit;
  assign rd_any = sel && !we;
  assign rd_hit = rd_any && in_map;
  assign wr_hit = sel && we && in_map;

  assign rd_rxd  = rd_hit && (idx == IDX_RXD);
  assign rd_stat = rd_hit && (idx == IDX_STAT);
  assign wr_txd  = wr_hit && (idx == IDX_TXD);
  assign wr_stat = wr_hit && (idx == IDX_STAT);
  assign wr_ctrl = wr_hit && (idx == IDX_CTRL);
endmodule

// File: rtl/uart_rx_ring.sv
`timescale 1ns/1ps
module uart_rx_ring #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  input  logic          clear,
  output logic [DW-1:0] out_data,
  output logic          accept,
  output logic [CW-1:0] count,
  output logic [PW-1:0] wptr,
  output logic          overrun
);
  logic [CW-1:0] count_q;
  logic [PW-1:0] wptr_q;
  logic          ovr_q;
  logic [PW-1:0] rslot;
  logic          drop, dec;
  logic [DW-1:0] slot_val [DEPTH];

  assign in_ready = count_q != CW'(DEPTH);
  assign accept   = in_valid && in_ready && !clear;
  assign drop     = in_valid && !in_ready && !clear;
  assign dec      = pop && (count_q != '0);
  assign rslot    = wptr_q - count_q[PW-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (accept && wptr_q == PW'(g))     q <= in_data;
    end
    assign slot_val[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wptr_q  <= '0;
      ovr_q   <= 1'b0;
    end else if (clear) begin
      count_q <= '0;
      wptr_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      count_q <= count_q + CW'(accept) - CW'(dec);
      if (accept) wptr_q <= wptr_q + 1'b1;
      if (drop)   ovr_q  <= 1'b1;
    end
  end

  assign out_data = slot_val[rslot];
  assign count    = count_q;
  assign wptr     = wptr_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/uart_stat_irq.sv
`timescale 1ns/1ps
module uart_stat_irq
  import uart_regfront_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic              push,
  input  logic              stat_rd,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              overrun,
  input  logic              irq_en,
  output logic              pend,
  output logic [WORD_W-1:0] status,
  output logic              irq
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pend_q <= 1'b0;
    else if (tx_wr || push)                  pend_q <= 1'b1;
    else if (stat_rd && rx_empty)            pend_q <= 1'b0;
  end

  always_comb begin
    status              = '0;
    status[ST_RXAVAIL]  = !rx_empty;
    status[ST_RXFULL]   = rx_full;
    status[ST_TXEMPTY]  = 1'b1;
    status[ST_TXFULL]   = 1'b0;
    status[ST_PEND]     = pend_q;
    status[ST_OVR]      = overrun;
  end

  assign pend = pend_q;
  assign irq  = pend_q && irq_en;
endmodule

// File: rtl/uart_regfront.sv
`timescale 1ns/1ps
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int DEPTH   = 8,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq,
  output logic              status_wr_err
);
  logic              rd_any, in_map, rd_rxd, rd_stat, wr_txd, wr_stat, wr_ctrl;
  reg_idx_e          idx;
  logic [WORD_W-1:0] ctrl_q, tx_q, status_w;
  logic [BYTE_W-1:0] ring_out;
  logic              rx_accept, rx_clear, ovr_q, pend_q;
  logic [CW-1:0]     rx_count;
  logic [PW-1:0]     rx_wptr;

  uart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .rd_any(rd_any), .in_map(in_map), .idx(idx),
    .rd_rxd(rd_rxd), .rd_stat(rd_stat), .wr_txd(wr_txd),
    .wr_stat(wr_stat), .wr_ctrl(wr_ctrl)
  );

  assign rx_clear = wr_ctrl && bus_wdata[CT_RXRST];

  uart_rx_ring #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_ready(rx_ready), .in_data(rx_data),
    .pop(rd_rxd), .clear(rx_clear), .out_data(ring_out),
    .accept(rx_accept), .count(rx_count), .wptr(rx_wptr), .overrun(ovr_q)
  );

  uart_stat_irq #(.WORD_W(WORD_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .tx_wr(wr_txd), .push(rx_accept), .stat_rd(rd_stat),
    .rx_empty(rx_count == '0), .rx_full(rx_count == CW'(DEPTH)),
    .overrun(ovr_q), .irq_en(ctrl_q[CT_IE]),
    .pend(pend_q), .status(status_w), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_txd)  tx_q   <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any && in_map) begin
      unique case (idx)
        IDX_RXD:  bus_rdata = WORD_W'(ring_out);
        IDX_TXD:  bus_rdata = tx_q;
        IDX_STAT: bus_rdata = status_w;
        IDX_CTRL: bus_rdata = ctrl_q;
      endcase
    end
  end

  assign tx_strobe     = wr_txd;
  assign tx_byte       = wr_txd ? bus_wdata[BYTE_W-1:0] : '0;
  assign status_wr_err = wr_stat;
endmodule

// File: rtl/uart_regfront_chk.sv
`timescale 1ns/1ps
module uart_regfront_chk #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              irq,
  input logic              status_wr_err,
  input logic [CW-1:0]     rx_count,
  input logic [PW-1:0]     rx_wptr,
  input logic              pend_q,
  input logic              ovr_q
);
  logic ctl_wr, rxrst;
  assign ctl_wr = bus_sel && bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign rxrst  = ctl_wr && bus_wdata[1];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH)); // R5
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH)) |-> !rx_ready); // R6
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rxrst) |=> $stable(rx_wptr)); // R6
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rxrst |=> (rx_count == '0 && rx_wptr == '0 && !ovr_q)); // R4
  AST_PEND_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0) |-> pend_q); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[4]) |=> !irq); // R2
  AST_TX_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (bus_we && tx_byte == bus_wdata[BYTE_W-1:0])); // R8
  AST_TX_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> pend_q); // R8
  AST_STAT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr_err && !rx_valid) |=> ($stable(rx_count) && $stable(pend_q) && $stable(ovr_q))); // R10
endmodule

bind uart_regfront uart_regfront_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
  .irq(irq), .status_wr_err(status_wr_err), .rx_count(rx_count),
  .rx_wptr(rx_wptr), .pend_q(pend_q), .ovr_q(ovr_q)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_strobe;
  logic [7:0]  tx_byte;
  logic        irq, status_wr_err;

  always #2.5 clk = ~clk;

  uart_regfront u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq),
    .status_wr_err(status_wr_err)
  );

  int nchk = 0, nfail = 0;

  // behavioural reference
  int          m_mem [8];
  int          m_wp = 0, m_cnt = 0;
  bit          m_pend = 0, m_ovr = 0;
  logic [31:0] m_ctrl = '0, m_tx = '0;

  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'h4;
    if (m_cnt > 0)  s[0] = 1'b1;
    if (m_cnt == 8) s[1] = 1'b1;
    if (m_pend)     s[4] = 1'b1;
    if (m_ovr)      s[5] = 1'b1;
    return s;
  endfunction

  task automatic check(input string name, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", name, got, exp);
    end
  endtask

  task automatic cyc(input bit sel, input bit we, input int addr, input logic [31:0] wd,
                     input bit rv, input logic [7:0] rd, input string tag);
    int idx;
    logic [31:0] exp;
    bit rdop, wrop, rst, acc, drop, pop;
    string nm;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = addr[7:0]; bus_wdata = wd;
    rx_valid = rv; rx_data = rd;
    #1;
    idx  = addr >> 2;
    rdop = sel && !we;
    wrop = sel && we;
    check("R6 rx_ready", {31'b0, rx_ready}, {31'b0, m_cnt < 8});
    check("R9 irq", {31'b0, irq}, {31'b0, m_pend && m_ctrl[4]});
    check("R8 tx_strobe", {31'b0, tx_strobe}, {31'b0, wrop && idx == 1});
    if (wrop && idx == 1) check("R8 tx_byte", {24'b0, tx_byte}, {24'b0, wd[7:0]});
    check("R10 status_wr_err", {31'b0, status_wr_err}, {31'b0, wrop && idx == 2});
    if (rdop) begin
      case (idx)
        0: begin exp = 32'(m_mem[(m_wp - m_cnt) & 7] & 255); nm = "R7 rx read"; end
        1: begin exp = m_tx;       nm = "R8 tx readback"; end
        2: begin exp = m_status(); nm = "R3 status"; end
        3: begin exp = m_ctrl;     nm = "R2 ctrl readback"; end
        default: begin exp = '0;   nm = "R1 unmapped read"; end
      endcase
      if (tag != "") nm = tag;
      check(nm, bus_rdata, exp);
    end
    rst  = wrop && idx == 3 && wd[1];
    acc  = rv && m_cnt < 8 && !rst;
    drop = rv && m_cnt == 8 && !rst;
    pop  = rdop && idx == 0 && m_cnt > 0;
    @(posedge clk);
    if (rst) begin
      m_wp = 0; m_cnt = 0; m_ovr = 0;
    end else begin
      if (acc) begin m_mem[m_wp] = int'(rd); m_wp = (m_wp + 1) & 7; end
      m_cnt = m_cnt + (acc ? 1 : 0) - (pop ? 1 : 0);
      if (drop) m_ovr = 1;
    end
    if ((wrop && idx == 1) || acc) m_pend = 1;
    else if (rdop && idx == 2 && m_cnt == 0) m_pend = 0;
    if (wrop && idx == 3) m_ctrl = wd;
    if (wrop && idx == 1) m_tx = wd;
  endtask

  task automatic rdreg(input int addr, input string tag);
    cyc(1, 0, addr, '0, 0, '0, tag);
  endtask
  task automatic wrreg(input int addr, input logic [31:0] v);
    cyc(1, 1, addr, v, 0, '0, "");
  endtask
  task automatic push(input logic [7:0] b);
    cyc(0, 0, 0, '0, 1, b, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rdreg(8, "R11 status after reset");
    rdreg(12, "R11 ctrl after reset");
    rdreg(4, "R11 tx after reset");
    // basic order
    push(8'h11); push(8'h22); push(8'h33);
    rdreg(8, "R3 status with 3 bytes");
    for (int i = 0; i < 3; i++) rdreg(0, "R5 in-order read");
    // empty reads, no underflow
    rdreg(0, "R7 empty read");
    rdreg(0, "R7 second empty read");
    rdreg(8, "R7 status after empty reads");
    rdreg(8, "R9 pending cleared after status read");
    // fill past capacity, wrapped pointer
    for (int i = 0; i < 9; i++) push(8'hA0 + 8'(i));
    rdreg(8, "R6 status full with overrun");
    for (int i = 0; i < 8; i++) rdreg(0, "R5 wrapped read");
    rdreg(8, "R9 status pending held until empty read");
    // TX and interrupt
    wrreg(12, 32'h0000_0010);
    rdreg(8, "R9 status clears pending");
    wrreg(4, 32'h0000_01A5);
    rdreg(4, "R8 tx readback");
    cyc(0, 0, 0, '0, 0, '0, "");
    rdreg(8, "R9 status read empty clears");
    // illegal status write
    push(8'h5C);
    wrreg(8, 32'hFFFF_FFFF);
    rdreg(8, "R10 status unchanged by write");
    // RX reset with simultaneous byte
    push(8'h6D);
    cyc(1, 1, 12, 32'h0000_0012, 1, 8'h77, "");
    rdreg(8, "R4 status after rx reset");
    rdreg(12, "R2 ctrl stored");
    // unmapped and index-0 writes
    wrreg(24, 32'hDEAD_BEEF);
    rdreg(24, "R1 index 6 reads zero");
    rdreg(16, "R1 index 4 reads zero");
    wrreg(0, 32'h0000_0099);
    rdreg(8, "R1 rx write ignored");
    // same-cycle push and pop
    cyc(1, 0, 0, '0, 1, 8'h42, "R12 pop+push on empty");
    cyc(1, 0, 0, '0, 1, 8'h43, "R12 pop+push nonempty");
    rdreg(8, "R12 status count one");
    rdreg(0, "R12 remaining byte");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom_range(0, 5)) * 4;
      bit s = ($urandom_range(0, 3) != 0);
      bit w = $urandom_range(0, 1) == 1;
      logic [31:0] d = $urandom;
      if (a == 12 && $urandom_range(0, 7) != 0) d[1] = 1'b0;
      cyc(s, w, a, d, $urandom_range(0, 1) == 1, 8'($urandom), "");
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule